// File: doc/BRIEF.md
# Verticalized Mealy Microoperation Controller

This block is a fixed-table Mealy control unit in which every operational step that needs several microoperations has been unrolled into a chain of states. Each state in a chain emits one microoperation per clock as a compact binary code. One decoder expands that code into one-hot microoperation lines. Because no state ever emits two microoperations at once, a single decoder covers the whole microoperation set.

A sticky collection register ORs the decoded lines together while a hold flag says the step is still incomplete. On the transition that completes a step (hold flag low), the gathered set is moved to the output register and shown to the datapath for one cycle with a valid strobe. The collection register is cleared at the same time. The datapath therefore sees each original step's microoperations all at once, even though the controller produced them serially.

States, in the order the machine visits them: ENTRY (code 0010), SECOND (0011), BRANCH (0100), TAKEN (0101), ALT1 (0110), ALT2 (0111). Transitions: ENTRY to SECOND; SECOND to BRANCH; BRANCH to TAKEN when x1 is 1; BRANCH to ALT1 when x1 is 0; ALT1 to ALT2; TAKEN, ALT2 and any unused code return to ENTRY.

Top module: `vmo_ctrl`

## Requirements
- R1: Synchronous reset puts the machine in ENTRY and clears the collection and output registers, so mop_vec is 0 and mop_valid is 0 after the reset edge. Reset wins over a step completing on the same edge.
- R2: The microoperation code is ceil(log2(N+1)) bits wide (4 bits for N = 10). Code value n selects yn and code 0 selects nothing. The decoder drives bit n-1 of the one-hot line vector for yn, and mop_vec uses the same bit order.
- R3: ENTRY goes to SECOND emitting y1 with hold high. SECOND goes to BRANCH emitting y2 with hold low, so the step {y1,y2} (mop_vec = 0x003) is released.
- R4: In BRANCH with x1 = 1 the machine goes to TAKEN emitting y3 with hold low (release of 0x004). With x1 = 0 it goes to ALT1 emitting y4 with hold high (no release).
- R5: ALT1 goes to ALT2 emitting y5 with hold low (release of {y4,y5} = 0x018). TAKEN, ALT2 and unused codes go to ENTRY emitting code 0 with hold high.
- R6: While hold is high, decoded bits accumulate and stay set. A released vector is the OR of every microoperation of that step and contains nothing from an earlier step.
- R7: mop_valid is 1 for exactly the cycle after a transition with hold low, and mop_vec then carries the step's set. In every cycle where mop_valid is 0, mop_vec is 0.
- R8: x1 affects the machine only in BRANCH. Its value in any other state changes neither the path nor the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| x1 | input | 1 | Condition bit sampled in BRANCH |
| mop_vec | output | 10 | Collected microoperation set, bit n-1 = yn |
| mop_valid | output | 1 | One-cycle strobe marking mop_vec as a complete step |

## Verification
The bench drives x1 to the opposite of its branch value in every state except BRANCH. A design that sampled the condition elsewhere would take the wrong path and release the wrong set. It applies reset in ALT1, where y4 is already gathered and the same edge would otherwise complete the step. A design that let release beat reset, or kept stale bits, would show y4 inside the next step's {y1,y2}. Back-to-back completions (SECOND then BRANCH to TAKEN) check that the register is cleared between steps, so 0x004 is not merged with 0x003. The return transitions must leave mop_vec at zero and the strobe low.

// File: rtl/vmo_pkg.sv
package vmo_pkg;
    localparam int MOP_N  = 10;
    localparam int CODE_W = $clog2(MOP_N + 1);

    typedef enum logic [3:0] {
        ST_ENTRY  = 4'b0010,
        ST_SECOND = 4'b0011,
        ST_BRANCH = 4'b0100,
        ST_TAKEN  = 4'b0101,
        ST_ALT1   = 4'b0110,
        ST_ALT2   = 4'b0111
    } state_t;
endpackage

// File: rtl/vmo_fsm.sv
module vmo_fsm
    import vmo_pkg::*;
#(
    parameter int MOP_N = vmo_pkg::MOP_N,
    localparam int CODE_W = $clog2(MOP_N + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              x1,
    output logic [CODE_W-1:0] mop_code,
    output logic              hold
);
    state_t state_q;
    state_t state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_ENTRY;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d  = ST_ENTRY;
        mop_code = '0;
        hold     = 1'b1;
        unique case (state_q)
            ST_ENTRY: begin
                state_d  = ST_SECOND;
                mop_code = CODE_W'(1);
                hold     = 1'b1;
            end
            ST_SECOND: begin
                state_d  = ST_BRANCH;
                mop_code = CODE_W'(2);
                hold     = 1'b0;
            end
            ST_BRANCH: begin
                if (x1) begin
                    state_d  = ST_TAKEN;
                    mop_code = CODE_W'(3);
                    hold     = 1'b0;
                end else begin
                    state_d  = ST_ALT1;
                    mop_code = CODE_W'(4);
                    hold     = 1'b1;
                end
            end
            ST_ALT1: begin
                state_d  = ST_ALT2;
                mop_code = CODE_W'(5);
                hold     = 1'b0;
            end
            ST_TAKEN, ST_ALT2: begin
                state_d  = ST_ENTRY;
                mop_code = '0;
                hold     = 1'b1;
            end
            default: begin
                state_d  = ST_ENTRY;
                mop_code = '0;
                hold     = 1'b1;
            end
        endcase
    end

    // R3: the entry state always advances to the second state
    a_r3_entry_to_second: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_ENTRY |=> state_q == ST_SECOND);

    // R4: branch with x1 high takes the short path
    a_r4_branch_taken: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BRANCH && x1) |=> state_q == ST_TAKEN);

    // R5: end states return to entry
    a_r5_return_entry: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TAKEN || state_q == ST_ALT2) |=> state_q == ST_ENTRY);
endmodule

// File: rtl/vmo_decoder.sv
module vmo_decoder #(
    parameter int MOP_N = vmo_pkg::MOP_N,
    localparam int CODE_W = $clog2(MOP_N + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] mop_code,
    output logic [MOP_N-1:0]  mop_lines
);
    for (genvar i = 0; i < MOP_N; i++) begin : g_line
        assign mop_lines[i] = (mop_code == CODE_W'(i + 1));
    end

    // R2: at most one microoperation line is active per cycle
    a_r2_single_line: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mop_lines));

    // R2: code zero selects no line
    a_r2_zero_code: assert property (@(posedge clk) disable iff (rst)
        mop_code == '0 |-> mop_lines == '0);
endmodule

// File: rtl/vmo_collect.sv
module vmo_collect #(
    parameter int MOP_N = vmo_pkg::MOP_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic [MOP_N-1:0] mop_lines,
    output logic [MOP_N-1:0] rel_vec,
    output logic             rel_valid
);
    logic [MOP_N-1:0] acc_q;
    logic [MOP_N-1:0] merged;

    assign merged = acc_q | mop_lines;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            rel_vec   <= '0;
            rel_valid <= 1'b0;
        end else if (!hold) begin
            acc_q     <= '0;
            rel_vec   <= merged;
            rel_valid <= 1'b1;
        end else begin
            acc_q     <= merged;
            rel_vec   <= '0;
            rel_valid <= 1'b0;
        end
    end

    // R6: bits already gathered stay set while the step is incomplete
    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        hold |=> ((acc_q & $past(acc_q)) == $past(acc_q)));

    // R7: the output vector is zero whenever the strobe is low
    a_r7_zero_idle: assert property (@(posedge clk) disable iff (rst)
        !rel_valid |-> rel_vec == '0);

    // R7: the strobe never lasts past the cycle after a completing transition
    a_r7_strobe_source: assert property (@(posedge clk) disable iff (rst)
        hold |=> !rel_valid);
endmodule

// File: rtl/vmo_ctrl.sv
module vmo_ctrl #(
    parameter int MOP_N = vmo_pkg::MOP_N,
    localparam int CODE_W = $clog2(MOP_N + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             x1,
    output logic [MOP_N-1:0] mop_vec,
    output logic             mop_valid
);
    logic [CODE_W-1:0] mop_code;
    logic              hold;
    logic [MOP_N-1:0]  mop_lines;

    vmo_fsm #(.MOP_N(MOP_N)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .x1       (x1),
        .mop_code (mop_code),
        .hold     (hold)
    );

    vmo_decoder #(.MOP_N(MOP_N)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .mop_code  (mop_code),
        .mop_lines (mop_lines)
    );

    vmo_collect #(.MOP_N(MOP_N)) u_col (
        .clk       (clk),
        .rst       (rst),
        .hold      (hold),
        .mop_lines (mop_lines),
        .rel_vec   (mop_vec),
        .rel_valid (mop_valid)
    );

    // R1: a reset edge leaves no strobe behind, even if a step completed
    always_ff @(posedge clk) begin
        if ($past(rst)) begin
            a_r1_reset_clear: assert (!mop_valid && mop_vec == '0);
        end
    end
endmodule

// File: tb/vmo_ctrl_tb.sv
module vmo_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       x1  = 1'b0;
    logic [9:0] mop_vec;
    logic       mop_valid;

    typedef struct {
        logic       v;
        logic [9:0] vec;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    logic mon_en   = 1'b0;

    vmo_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .x1        (x1),
        .mop_vec   (mop_vec),
        .mop_valid (mop_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // monitor: one expected item per cycle, sampled after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (mon_en && exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (mop_valid !== e.v || mop_vec !== e.vec) begin
                    n_fail++;
                    $display("FAIL %s: valid=%b vec=%h expected valid=%b vec=%h",
                             e.tag, mop_valid, mop_vec, e.v, e.vec);
                end
            end
        end
    end

    task automatic step(input logic xv, input logic ev, input logic [9:0] evec,
                        input string tag);
        exp_t e;
        x1    = xv;
        e.v   = ev;
        e.vec = evec;
        e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    // one full walk from ENTRY; x1 is inverted outside BRANCH (R8)
    task automatic run_pass(input logic xv);
        step(~xv, 1'b0, 10'h000, "R5 return no release, R8");
        step(~xv, 1'b0, 10'h000, "R3 y1 held");
        step(xv,  1'b1, 10'h003, "R3 R6 R7 release y1,y2");
        if (xv) begin
            step(~xv, 1'b1, 10'h004, "R4 R7 release y3, R8");
        end else begin
            step(~xv, 1'b0, 10'h000, "R4 y4 held, R8");
            step(~xv, 1'b1, 10'h018, "R5 R6 release y4,y5");
        end
    endtask

    // reset applied in ALT1 while y4 is gathered and y5 would complete
    task automatic run_cut();
        step(1'b1, 1'b0, 10'h000, "R5 return no release");
        step(1'b1, 1'b0, 10'h000, "R3 y1 held");
        step(1'b0, 1'b1, 10'h003, "R3 release y1,y2");
        rst = 1'b1;
        step(1'b1, 1'b0, 10'h000, "R1 before reset edge");
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        n_checks++;
        if (mop_valid !== 1'b0 || mop_vec !== 10'h000) begin
            n_fail++;
            $display("FAIL R1 reset state: valid=%b vec=%h expected valid=0 vec=000",
                     mop_valid, mop_vec);
        end
        @(negedge clk);
        rst    = 1'b0;
        mon_en = 1'b1;
        run_pass(1'b1);
        run_pass(1'b0);
        run_pass(1'b1);
        run_cut();
        run_pass(1'b1);   // stale y4 would show as 0x00B in R1/R6 check
        run_pass(1'b0);
        run_pass(1'b0);
        run_pass(1'b1);
        step(1'b0, 1'b0, 10'h000, "R5 final return");
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule